// File: doc/BRIEF.md
# Interval Timer Bus Register Interface

This block is the byte-wide register front end of a three-channel interval timer. A 2-bit address selects one of three channel data ports (addresses 0 to 2) or the shared control port (address 3). The block decodes control bytes into per-channel settings. It steps each channel through its low-byte and high-byte access order, and it holds a count snapshot and a status snapshot for each channel until software reads them out.

The counting engines sit outside this block. Each engine presents its live 16-bit count and its output level to this block. In return, the block gives each engine a one-cycle load strobe with a 16-bit start value, plus the engine's mode and decimal-count flag. A bus cycle is a single-cycle `bus_wr` or `bus_rd` pulse. Read data is combinational and valid during the read cycle. The side effects of a read, such as releasing a snapshot or flipping a byte toggle, take effect at the closing clock edge. If `bus_wr` and `bus_rd` are asserted together, the write is performed and the read is ignored.

Top module: `tmr_busif`

## Requirements
- R1: After reset, no load strobe is active, every channel reports mode 0 and decimal flag 0, every channel uses two-byte access (low byte then high byte), no snapshots are held, and both byte toggles of every channel point at the low byte.
- R2: A control write with bits 7:6 equal to 0, 1 or 2 and a nonzero bits 5:4 programs that channel. Bits 5:4 set the access type: 1 is low byte only, 2 is high byte only, 3 is low then high. Bits 3:1 set the mode and bit 0 sets the decimal flag. The new mode and flag appear on `ch_mode_o` and `ch_bcd_o` after the write's clock edge. The write also returns the channel's read toggle and write toggle to the low byte.
- R3: A data write to a channel in low-only access loads {8'h00, byte}. In high-only access it loads {byte, 8'h00}. In two-byte access the first byte is held and nothing is loaded; the second byte loads {second, first}. The load strobe is high for exactly one cycle, starting after the write's edge, on that channel only.
- R4: A control write whose bits 7:6 select a channel and whose bits 5:4 are 0 takes a snapshot of that channel's live count. The request is ignored while a count snapshot for that channel is still unread.
- R5: A control write with bits 7:6 equal to 3 is a read-back command. Bit 1, bit 2 and bit 3 select channels 0, 1 and 2. For each selected channel, bit 5 at 0 takes a count snapshot and bit 4 at 0 takes a status snapshot.
- R6: A status byte holds the channel output level in bit 7, 0 in bit 6, the access type in bits 5:4, the mode in bits 3:1, and the decimal flag in bit 0. All fields are sampled when the snapshot is taken.
- R7: A data read returns a held status byte first, and that read releases the status byte. With no status held, the read returns the held count snapshot. With neither held, it returns the live count.
- R8: In two-byte access, a held count snapshot is read as its low byte and then its high byte, and is released after the high byte. In low-only access it yields only the low byte, and in high-only access only the high byte; in either case the snapshot is released after that one read.
- R9: Live-count reads in two-byte access alternate between the low byte and the high byte, starting with the low byte. Each channel keeps its own toggle, and reads of a held snapshot do not advance it.
- R10: A read at the control port address returns 8'h00 and changes no state.
- R11: A status snapshot request is ignored while an unread status byte is held for that channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 2 | 0 to 2 channel data port, 3 control port |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid while bus_rd is high |
| ch_count_i | input | 48 | Live 16-bit count per channel, channel 0 in the low bits |
| ch_out_i | input | 3 | Output level per channel |
| ch_load_o | output | 3 | One-cycle load strobe per channel |
| ch_load_val_o | output | 48 | 16-bit start value per channel, valid with its strobe |
| ch_mode_o | output | 9 | 3-bit mode per channel |
| ch_bcd_o | output | 3 | Decimal count flag per channel |

## Verification
Errors in the byte-toggle or snapshot state do not show up at the write that causes them. They show up at a later data read, which returns the wrong half of a count or returns a stale or live value where a held one was due. A broken write toggle shows up one write later, as a load strobe that is missing or comes too early. The tests therefore read out several bytes after each snapshot command, change the live inputs between a snapshot and its readout, and read from several channels in turn to expose toggles that are shared between channels.

// File: rtl/tmr_busif_pkg.sv
package tmr_busif_pkg;

    parameter int BYTE_W  = 8;
    parameter int CNT_W   = 16;
    parameter int NUM_CH  = 3;
    parameter int ADDR_W  = 2;
    parameter int MODE_W  = 3;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(3);

    // access type field, encoding fixed by the control byte bits 5:4
    typedef enum logic [1:0] {
        ACC_LATCH = 2'd0,
        ACC_LO    = 2'd1,
        ACC_HI    = 2'd2,
        ACC_WORD  = 2'd3
    } acc_e;

    typedef struct packed {
        acc_e              acc;
        logic [MODE_W-1:0] mode;
        logic              bcd;
    } chan_cfg_t;

    typedef struct packed {
        logic [NUM_CH-1:0] prog;
        logic [NUM_CH-1:0] snap_cnt;
        logic [NUM_CH-1:0] snap_sts;
        chan_cfg_t         cfg;
    } ctrl_cmd_t;

    localparam chan_cfg_t CFG_RESET = '{acc: ACC_WORD, mode: '0, bcd: 1'b0};

    function automatic logic [BYTE_W-1:0] status_byte(logic out_lvl, chan_cfg_t c);
        return {out_lvl, 1'b0, c.acc, c.mode, c.bcd};
    endfunction

    function automatic logic [BYTE_W-1:0] half_of(logic [CNT_W-1:0] v, logic upper);
        return upper ? v[CNT_W-1 -: BYTE_W] : v[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
    import tmr_busif_pkg::*;
(
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] wdata,
    output ctrl_cmd_t         cmd
);

    localparam logic [1:0] SEL_READBACK = 2'd3;

    logic [1:0] sel;
    assign sel = wdata[7:6];

    always_comb begin
        cmd          = '0;
        cmd.cfg.acc  = acc_e'(wdata[5:4]);
        cmd.cfg.mode = wdata[3:1];
        cmd.cfg.bcd  = wdata[0];
        if (ctrl_wr) begin
            if (sel == SEL_READBACK) begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (wdata[c+1]) begin
                        cmd.snap_cnt[c] = ~wdata[5];
                        cmd.snap_sts[c] = ~wdata[4];
                    end
                end
            end else begin
                for (int c = 0; c < NUM_CH; c++) begin
                    if (sel == 2'(c)) begin
                        if (wdata[5:4] == 2'd0)
                            cmd.snap_cnt[c] = 1'b1;
                        else
                            cmd.prog[c] = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
    import tmr_busif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              cmd_prog,
    input  logic              cmd_snap_cnt,
    input  logic              cmd_snap_sts,
    input  chan_cfg_t         new_cfg,
    input  logic [CNT_W-1:0]  live_cnt,
    input  logic              out_lvl,
    output logic [BYTE_W-1:0] rd_byte,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output chan_cfg_t         cfg
);

    chan_cfg_t         cfg_q;
    logic              wr_hi_q;
    logic [BYTE_W-1:0] hold_q;
    logic              rd_hi_q;
    acc_e              snap_q;       // ACC_LATCH means no count held
    logic [CNT_W-1:0]  snap_val_q;
    logic              sts_pend_q;
    logic [BYTE_W-1:0] sts_q;
    logic              load_q;
    logic [CNT_W-1:0]  load_val_q;

    always_comb begin
        if (sts_pend_q)
            rd_byte = sts_q;
        else if (snap_q != ACC_LATCH)
            rd_byte = half_of(snap_val_q, snap_q == ACC_HI);
        else begin
            unique case (cfg_q.acc)
                ACC_HI:   rd_byte = half_of(live_cnt, 1'b1);
                ACC_WORD: rd_byte = half_of(live_cnt, rd_hi_q);
                default:  rd_byte = half_of(live_cnt, 1'b0);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q      <= CFG_RESET;
            wr_hi_q    <= 1'b0;
            hold_q     <= '0;
            rd_hi_q    <= 1'b0;
            snap_q     <= ACC_LATCH;
            snap_val_q <= '0;
            sts_pend_q <= 1'b0;
            sts_q      <= '0;
            load_q     <= 1'b0;
            load_val_q <= '0;
        end else begin
            load_q <= 1'b0;
            if (cmd_prog) begin
                cfg_q   <= new_cfg;
                wr_hi_q <= 1'b0;
                rd_hi_q <= 1'b0;
            end
            if (cmd_snap_cnt && snap_q == ACC_LATCH) begin
                snap_val_q <= live_cnt;
                snap_q     <= cfg_q.acc;
            end
            if (cmd_snap_sts && !sts_pend_q) begin
                sts_q      <= status_byte(out_lvl, cfg_q);
                sts_pend_q <= 1'b1;
            end
            if (data_wr) begin
                unique case (cfg_q.acc)
                    ACC_HI: begin
                        load_q     <= 1'b1;
                        load_val_q <= {wdata, {BYTE_W{1'b0}}};
                    end
                    ACC_WORD: begin
                        if (!wr_hi_q) begin
                            hold_q  <= wdata;
                            wr_hi_q <= 1'b1;
                        end else begin
                            load_q     <= 1'b1;
                            load_val_q <= {wdata, hold_q};
                            wr_hi_q    <= 1'b0;
                        end
                    end
                    default: begin
                        load_q     <= 1'b1;
                        load_val_q <= {{BYTE_W{1'b0}}, wdata};
                    end
                endcase
            end
            if (data_rd) begin
                if (sts_pend_q)
                    sts_pend_q <= 1'b0;
                else if (snap_q != ACC_LATCH)
                    snap_q <= (snap_q == ACC_WORD) ? ACC_HI : ACC_LATCH;
                else if (cfg_q.acc == ACC_WORD)
                    rd_hi_q <= ~rd_hi_q;
            end
        end
    end

    assign load     = load_q;
    assign load_val = load_val_q;
    assign cfg      = cfg_q;

endmodule

// File: rtl/tmr_busif.sv
module tmr_busif
    import tmr_busif_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [BYTE_W-1:0]        bus_wdata,
    output logic [BYTE_W-1:0]        bus_rdata,
    input  logic [NUM_CH*CNT_W-1:0]  ch_count_i,
    input  logic [NUM_CH-1:0]        ch_out_i,
    output logic [NUM_CH-1:0]        ch_load_o,
    output logic [NUM_CH*CNT_W-1:0]  ch_load_val_o,
    output logic [NUM_CH*MODE_W-1:0] ch_mode_o,
    output logic [NUM_CH-1:0]        ch_bcd_o
);

    logic      rd_en;
    logic      ctrl_wr;
    ctrl_cmd_t cmd;
    logic [BYTE_W-1:0] rd_bytes [NUM_CH];

    assign rd_en   = bus_rd & ~bus_wr;
    assign ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);

    tmr_ctrl_decode u_dec (
        .ctrl_wr (ctrl_wr),
        .wdata   (bus_wdata),
        .cmd     (cmd)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chan_cfg_t cfg_c;
        logic      hit;
        assign hit = (bus_addr == ADDR_W'(c));

        tmr_chan_regs u_ch (
            .clk          (clk),
            .rst          (rst),
            .data_wr      (bus_wr & hit),
            .data_rd      (rd_en & hit),
            .wdata        (bus_wdata),
            .cmd_prog     (cmd.prog[c]),
            .cmd_snap_cnt (cmd.snap_cnt[c]),
            .cmd_snap_sts (cmd.snap_sts[c]),
            .new_cfg      (cmd.cfg),
            .live_cnt     (ch_count_i[c*CNT_W +: CNT_W]),
            .out_lvl      (ch_out_i[c]),
            .rd_byte      (rd_bytes[c]),
            .load         (ch_load_o[c]),
            .load_val     (ch_load_val_o[c*CNT_W +: CNT_W]),
            .cfg          (cfg_c)
        );

        assign ch_mode_o[c*MODE_W +: MODE_W] = cfg_c.mode;
        assign ch_bcd_o[c]                   = cfg_c.bcd;
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            for (int c = 0; c < NUM_CH; c++)
                if (bus_addr == ADDR_W'(c))
                    bus_rdata = rd_bytes[c];
        end
    end

endmodule

// File: rtl/tmr_busif_chk.sv
module tmr_busif_chk
    import tmr_busif_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_wr,
    input logic                     bus_rd,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [BYTE_W-1:0]        bus_rdata,
    input logic [NUM_CH-1:0]        ch_load_o,
    input logic [NUM_CH*MODE_W-1:0] ch_mode_o,
    input logic [NUM_CH-1:0]        ch_bcd_o
);

    // R10
    ctrl_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !bus_wr && bus_addr == CTRL_ADDR) |-> bus_rdata == '0);

    // R3
    load_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_load_o));

    // R3
    load_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (|ch_load_o) |-> $past(bus_wr && bus_addr != CTRL_ADDR));

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> ch_load_o == '0);

    // R2
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(bus_wr && bus_addr == CTRL_ADDR) |-> ($stable(ch_mode_o) && $stable(ch_bcd_o)));

endmodule

bind tmr_busif tmr_busif_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .ch_load_o (ch_load_o),
    .ch_mode_o (ch_mode_o),
    .ch_bcd_o  (ch_bcd_o)
);

// File: tb/tmr_busif_tb.sv
module tmr_busif_tb;
    import tmr_busif_pkg::*;

    logic                     clk = 1'b0;
    logic                     rst = 1'b1;
    logic                     bus_wr = 1'b0;
    logic                     bus_rd = 1'b0;
    logic [ADDR_W-1:0]        bus_addr = '0;
    logic [BYTE_W-1:0]        bus_wdata = '0;
    logic [BYTE_W-1:0]        bus_rdata;
    logic [NUM_CH*CNT_W-1:0]  ch_count_i;
    logic [NUM_CH-1:0]        ch_out_i;
    logic [NUM_CH-1:0]        ch_load_o;
    logic [NUM_CH*CNT_W-1:0]  ch_load_val_o;
    logic [NUM_CH*MODE_W-1:0] ch_mode_o;
    logic [NUM_CH-1:0]        ch_bcd_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    tmr_busif u_dut (.*);

    // op[27:26]: 0 write, 1 read+check, 2 write+load check, 3 write+no load
    localparam int NVEC = 25;
    localparam logic [27:0] VEC [NVEC] = '{
        28'hC340000, 28'h8121234,                           // R3 word write
        28'h4000034, 28'h4000012, 28'h4000034,              // R9 live toggle
        28'h3500000, 28'h9770077,                           // R2 R3 low-only
        28'h50000CD, 28'h50000CD,
        28'h3A70000, 28'hA999900, 28'h600005A,              // R3 high-only
        28'h7000000,                                        // R10
        28'h3000000, 28'h4000034, 28'h4000012,              // R4 R8 snapshot
        28'h4000012, 28'h4000034,                           // R9 toggle kept
        28'h3E80000, 28'h60000A7, 28'h600005A,              // R5 R6 status
        28'h3C40000, 28'h5000010, 28'h50000CD, 28'h50000CD  // R7 R8 priority
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #5;
        chk(bus_rdata == exp, req, 32'(bus_rdata), 32'(exp));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk_load(input int ch, input bit want, input logic [15:0] val, input string req);
        logic [2:0] exp_mask;
        exp_mask = want ? 3'(1 << ch) : 3'b000;
        chk(ch_load_o == exp_mask, req, 32'(ch_load_o), 32'(exp_mask));
        if (want)
            chk(ch_load_val_o[ch*CNT_W +: CNT_W] == val, req,
                32'(ch_load_val_o[ch*CNT_W +: CNT_W]), 32'(val));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        ch_count_i = {16'h5A0F, 16'hABCD, 16'h1234};
        ch_out_i   = 3'b101;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(ch_load_o == '0, "R1 load", 32'(ch_load_o), 0);
        chk(ch_mode_o == '0, "R1 mode", 32'(ch_mode_o), 0);
        chk(ch_bcd_o == '0, "R1 bcd", 32'(ch_bcd_o), 0);

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  op, a;
            logic [7:0]  d;
            logic [15:0] e;
            {op, a, d, e} = VEC[i];
            case (op)
                2'd0: do_wr(a, d);
                2'd1: do_rd(a, e[7:0], $sformatf("R7 R8 R9 vec %0d", i));
                2'd2: begin do_wr(a, d); chk_load(a, 1'b1, e, $sformatf("R3 vec %0d", i)); end
                default: begin do_wr(a, d); chk_load(a, 1'b0, '0, $sformatf("R3 vec %0d", i)); end
            endcase
        end

        // R2 fields on outputs after programming ch2 with 0xA7
        chk(ch_mode_o[8:6] == 3'd3, "R2 mode ch2", 32'(ch_mode_o[8:6]), 3);
        chk(ch_bcd_o == 3'b100, "R2 bcd", 32'(ch_bcd_o), 32'b100);

        // R4 second count snapshot ignored while pending
        do_wr(2'd3, 8'h00);
        ch_count_i[15:0] = 16'h4321;
        do_wr(2'd3, 8'h00);
        do_rd(2'd0, 8'h34, "R4 held low");
        do_rd(2'd0, 8'h12, "R4 held high");
        do_wr(2'd3, 8'h00);
        do_rd(2'd0, 8'h21, "R4 new low");
        do_rd(2'd0, 8'h43, "R4 new high");

        // R11 second status snapshot ignored while pending; ch0 status 0xB0
        do_wr(2'd3, 8'hE2);
        ch_out_i[0] = 1'b0;
        do_wr(2'd3, 8'hE2);
        do_rd(2'd0, 8'hB0, "R11 R6 first status kept");

        // R2 control write resets toggles
        do_wr(2'd3, 8'h30);
        do_rd(2'd0, 8'h21, "R9 live low");
        do_wr(2'd3, 8'h30);
        do_rd(2'd0, 8'h21, "R2 read toggle reset");
        do_wr(2'd0, 8'h55);
        chk_load(0, 1'b0, '0, "R3 first byte held");
        do_wr(2'd3, 8'h30);
        do_wr(2'd0, 8'h66);
        chk_load(0, 1'b0, '0, "R2 write toggle reset");
        do_wr(2'd0, 8'h77);
        chk_load(0, 1'b1, 16'h7766, "R3 word load");

        // R9 separate toggles per channel
        do_wr(2'd3, 8'h70);
        do_rd(2'd0, 8'h21, "R9 ch0 low");
        do_rd(2'd1, 8'hCD, "R9 ch1 low");
        do_rd(2'd0, 8'h43, "R9 ch0 high");
        do_rd(2'd1, 8'hAB, "R9 ch1 high");

        // R5 read-back with count only on ch1 (word mode now)
        do_wr(2'd3, 8'hD4);
        ch_count_i[31:16] = 16'h0102;
        do_rd(2'd1, 8'hCD, "R5 ch1 snap low");
        do_rd(2'd1, 8'hAB, "R5 ch1 snap high");
        do_rd(2'd1, 8'h02, "R8 released live low");

        // R10 control read
        do_rd(2'd3, 8'h00, "R10 ctrl read");

        done = 1'b1;
        finish_run();
    end

endmodule